// File: doc/BRIEF.md
# Retriggerable Gated One-Shot Pulse Generator

This block is a synchronous monostable. It produces a single pulse on `q_o` whose length is a programmed number of clock cycles. It also drives the exact complement of that pulse on `qn_o`. Three control inputs can start the pulse:

- an active-low trigger `trig_n_i`;
- an active-high trigger `trig_i`;
- an active-low clear `clr_ni`.

All three are sampled on the system clock. An edge is found by comparing the newest sample with the one before it, and an edge only counts when the other two inputs sit at their enabling levels.

A qualifying trigger loads a down-counter with `len_i`. A trigger that arrives while a pulse runs reloads the counter. The pulse therefore ends one full programmed length after the last trigger, so repeated triggers can hold `q_o` high indefinitely.

Pulling the clear low forces the output idle as soon as the low level is sampled. It also discards the count and any trigger still in the pipeline. Clear always overrides a trigger.

Top module: `oneshot_gen`

## Requirements
- R1: While `rst_ni` is low, `q_o` = 0 and `qn_o` = 1. After reset is released, steady input levels (even `trig_n_i`=0, `trig_i`=1, `clr_ni`=1) start no pulse.
- R2: `qn_o` is always the exact complement of `q_o`.
- R3: A rising edge on `trig_i` while `trig_n_i`=0 and `clr_ni`=1 starts a pulse. Take the input change as sampled on clock edge 1. Then `q_o` is high after edges 3 through N+2 and low after edge N+3, where N is `len_i`.
- R4: A falling edge on `trig_n_i` while `trig_i`=1 and `clr_ni`=1 starts a pulse with the same timing as R3.
- R5: A rising edge on `clr_ni` while `trig_n_i`=0 and `trig_i`=1 starts a pulse with the same timing as R3.
- R6: On the clock edge that samples `clr_ni`=0, `q_o` drops to 0 and stays 0 while the clear is low. A running count is discarded, so releasing the clear without a qualifying edge leaves `q_o` at 0.
- R7: A qualifying trigger during a pulse reloads the counter. `q_o` stays high until N cycles after the reload, so the width is N plus the spacing between triggers. Triggers spaced closer than N cycles keep `q_o` high continuously.
- R8: A trigger with `len_i`=0 loads zero. No pulse starts, and a running pulse ends on the edge where the zero is loaded.
- R9: Steady levels and non-qualifying edges start no pulse. Non-qualifying edges are: a `trig_i` rise while `trig_n_i`=1, a `trig_n_i` fall while `trig_i`=0, a `clr_ni` rise while `trig_n_i`=1, a `trig_n_i` rise, and a `trig_i` fall.
- R10: A trigger pending in the pipeline is dropped if `clr_ni` is sampled low before it loads. An edge sampled together with `clr_ni`=0 does not trigger.
- R11: The length is taken from `len_i` on the clock edge where the counter loads. Later changes to `len_i` do not alter a running pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trig_n_i | input | 1 | Active-low trigger, fires on its falling edge |
| trig_i | input | 1 | Active-high trigger, fires on its rising edge |
| clr_ni | input | 1 | Active-low clear; its rising edge can also trigger |
| len_i | input | LEN_W | Pulse length in clock cycles |
| q_o | output | 1 | Pulse output |
| qn_o | output | 1 | Complement of the pulse output |

## Verification
Two pairs of functions can meet in one cycle.

The first pair is a trigger and a clear. The bench provokes this by raising `trig_i` and dropping `clr_ni` one cycle later, so the trigger is still pending when the clear is sampled. It also changes both on the same cycle. In both cases `q_o` is judged to stay low for the whole window and after the clear is released with `trig_n_i` high.

The second pair is a retrigger landing while a pulse is running. This is judged by the exact sample on which `q_o` falls: it must be N cycles after the last reload. Variants use a zero length and a periodic retrigger that must keep `q_o` continuously high.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
  typedef struct packed {
    logic a_n;
    logic b;
    logic clr_n;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{a_n: 1'b1, b: 1'b0, clr_n: 1'b1};
endpackage

// File: rtl/oneshot_sampler.sv
module oneshot_sampler
  import oneshot_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  ctl_t ctl_i,
  output ctl_t cur_o,
  output ctl_t prv_o,
  output logic vld_o
);
  ctl_t cur_q, prv_q;
  logic s_vld_q, p_vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q   <= CTL_IDLE;
      prv_q   <= CTL_IDLE;
      s_vld_q <= 1'b0;
      p_vld_q <= 1'b0;
    end else begin
      cur_q   <= ctl_i;
      prv_q   <= cur_q;
      s_vld_q <= 1'b1;
      p_vld_q <= s_vld_q;
    end
  end

  // edges are meaningful only once prv holds a real sample
  assign cur_o = cur_q;
  assign prv_o = prv_q;
  assign vld_o = p_vld_q;
endmodule

// File: rtl/oneshot_trig_detect.sv
module oneshot_trig_detect
  import oneshot_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  ctl_t cur_i,
  input  ctl_t prv_i,
  input  logic vld_i,
  output logic trig_o
);
  logic b_rise, a_fall, c_rise, hit;
  logic trig_q;

  assign b_rise = cur_i.b & ~prv_i.b;
  assign a_fall = ~cur_i.a_n & prv_i.a_n;
  assign c_rise = cur_i.clr_n & ~prv_i.clr_n;

  assign hit = vld_i & ((b_rise & ~cur_i.a_n & cur_i.clr_n) |
                        (a_fall &  cur_i.b   & cur_i.clr_n) |
                        (c_rise & ~cur_i.a_n & cur_i.b));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_q <= 1'b0;
    else         trig_q <= hit;
  end

  assign trig_o = trig_q;
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
  parameter int LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic             clr_ok_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             active_o
);
  localparam logic [LEN_W-1:0] CNT_ONE = LEN_W'(1);

  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!clr_ok_i)      cnt_q <= '0;
    else if (trig_i)         cnt_q <= len_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_ONE;
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/oneshot_gen.sv
module oneshot_gen
  import oneshot_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_n_i,
  input  logic             trig_i,
  input  logic             clr_ni,
  input  logic [LEN_W-1:0] len_i,
  output logic             q_o,
  output logic             qn_o
);
  ctl_t ctl_in, cur, prv;
  logic vld, trig_q, active, clr_s;

  assign ctl_in = '{a_n: trig_n_i, b: trig_i, clr_n: clr_ni};

  oneshot_sampler i_sampler (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ctl_i  (ctl_in),
    .cur_o  (cur),
    .prv_o  (prv),
    .vld_o  (vld)
  );

  oneshot_trig_detect i_detect (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cur_i  (cur),
    .prv_i  (prv),
    .vld_i  (vld),
    .trig_o (trig_q)
  );

  assign clr_s = cur.clr_n;

  oneshot_timer #(.LEN_W(LEN_W)) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .trig_i   (trig_q),
    .clr_ok_i (clr_s),
    .len_i    (len_i),
    .active_o (active)
  );

  // sampled clear gates the output on the same edge
  assign q_o  = active & clr_s;
  assign qn_o = ~q_o;
endmodule

// File: rtl/oneshot_chk.sv
module oneshot_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_ni,
  input logic [LEN_W-1:0] len_i,
  input logic             q_o,
  input logic             qn_o,
  input logic             trig_q,
  input logic             clr_s
);
  always_comb begin
    if (!rst_ni) begin
      p_reset_idle_r1: assert (!q_o && qn_o);
    end
  end

  p_compl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qn_o == !q_o);

  p_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_q && clr_s && clr_ni && len_i != '0) |=> q_o);

  p_clear_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(clr_ni) |-> !q_o);

  p_len_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_q && len_i == '0) |=> !q_o);

  p_no_spurious_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trig_q && !q_o) |=> !q_o);

  p_clear_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_q && !clr_s) |=> !q_o);
endmodule

bind oneshot_gen oneshot_chk #(.LEN_W(LEN_W)) i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .clr_ni (clr_ni),
  .len_i  (len_i),
  .q_o    (q_o),
  .qn_o   (qn_o),
  .trig_q (trig_q),
  .clr_s  (clr_s)
);

// File: tb/test_oneshot_gen.sv
module test_oneshot_gen;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 4;
  localparam int NMAX = (1 << LW) - 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic a_n = 1'b1;
  logic b = 1'b0;
  logic clr_n = 1'b1;
  logic [LW-1:0] len = '0;
  logic q, qn;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  oneshot_gen #(.LEN_W(LW)) i_oneshot_gen (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .trig_n_i (a_n),
    .trig_i   (b),
    .clr_ni   (clr_n),
    .len_i    (len),
    .q_o      (q),
    .qn_o     (qn)
  );

  task automatic chk(input bit ok, input string req, input int act, input int want);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, want);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // samples 1..nsamp after the change driven at the current negedge; high expected in [lo,hi]
  task automatic window(input string req, input int lo, input int hi, input int nsamp);
    int bad = 0;
    int highs = 0;
    int want_h;
    bit cbad = 1'b0;
    bit want;
    for (int k = 1; k <= nsamp; k++) begin
      @(negedge clk);
      want = (k >= lo) && (k <= hi);
      if (q !== want) bad++;
      if (q === 1'b1) highs++;
      if (qn !== ~q) cbad = 1'b1;
    end
    want_h = (hi >= lo) ? hi - lo + 1 : 0;
    chk(bad == 0, req, highs, want_h);
    chk(!cbad, "R2 complement", int'(cbad), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int bad;
    int highs;

    // R1: reset state, then steady enabling levels must not fire
    a_n = 1'b0; b = 1'b1; clr_n = 1'b1; len = 4'd5;
    step(3);
    chk(q === 1'b0, "R1 q in reset", int'(q), 0);
    chk(qn === 1'b1, "R1 qn in reset", int'(qn), 1);
    rst_ni = 1'b1;
    window("R1 no pulse after reset", 1, 0, 10);

    // R3 / R8: trig_i rising, full length sweep
    for (int n = 0; n <= NMAX; n++) begin
      len = LW'(n); a_n = 1'b0; b = 1'b0; clr_n = 1'b1;
      step(NMAX + 4);
      b = 1'b1;
      window(n == 0 ? "R8 zero length" : "R3 b rise", 3, n + 2, n + 6);
    end

    // R4: trig_n_i falling
    for (int n = 0; n <= NMAX; n++) begin
      len = LW'(n); a_n = 1'b1; b = 1'b1; clr_n = 1'b1;
      step(NMAX + 4);
      a_n = 1'b0;
      window(n == 0 ? "R8 zero length" : "R4 a fall", 3, n + 2, n + 6);
    end

    // R5: clr_ni rising
    for (int n = 0; n <= NMAX; n++) begin
      len = LW'(n); clr_n = 1'b0; a_n = 1'b0; b = 1'b1;
      step(NMAX + 4);
      clr_n = 1'b1;
      window(n == 0 ? "R8 zero length" : "R5 clr rise", 3, n + 2, n + 6);
    end

    // R7: one retrigger, width = 6 + 4
    len = 4'd6; a_n = 1'b0; b = 1'b0; clr_n = 1'b1;
    step(20);
    b = 1'b1;
    bad = 0; highs = 0;
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk);
      if (q !== ((k >= 3) && (k <= 12))) bad++;
      if (q === 1'b1) highs++;
      if (k == 2) b = 1'b0;
      if (k == 4) b = 1'b1;
    end
    chk(bad == 0, "R7 retrigger width", highs, 10);

    // R7: periodic retrigger keeps q high
    len = 4'd5; b = 1'b0;
    step(20);
    b = 1'b1;
    bad = 0;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (q !== (k >= 3)) bad++;
      if (k % 4 == 2) b = 1'b0;
      if (k % 4 == 0) b = 1'b1;
    end
    chk(bad == 0, "R7 continuous high", bad, 0);

    // R8: retrigger with zero length ends the pulse
    len = 4'd10; b = 1'b0;
    step(20);
    b = 1'b1;
    bad = 0; highs = 0;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      if (q !== ((k >= 3) && (k <= 6))) bad++;
      if (q === 1'b1) highs++;
      if (k == 2) b = 1'b0;
      if (k == 4) begin b = 1'b1; len = 4'd0; end
    end
    chk(bad == 0, "R8 zero reload", highs, 4);

    // R11: length latched at load
    len = 4'd4; b = 1'b0;
    step(20);
    b = 1'b1;
    bad = 0; highs = 0;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      if (q !== ((k >= 3) && (k <= 6))) bad++;
      if (q === 1'b1) highs++;
      if (k == 3) len = 4'd15;
    end
    chk(bad == 0, "R11 length latched", highs, 4);

    // R6: clear cuts the pulse and discards the count
    len = 4'd10; a_n = 1'b0; b = 1'b0; clr_n = 1'b1;
    step(20);
    b = 1'b1;
    bad = 0; highs = 0;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (q !== ((k >= 3) && (k <= 5))) bad++;
      if (q === 1'b1) highs++;
      if (k == 5) clr_n = 1'b0;
      if (k == 10) a_n = 1'b1;
      if (k == 11) clr_n = 1'b1;
    end
    chk(bad == 0, "R6 clear cut", highs, 3);

    // R10: clear lands while trigger is pending
    len = 4'd8; a_n = 1'b0; b = 1'b0; clr_n = 1'b1;
    step(20);
    b = 1'b1;
    bad = 0;
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk);
      if (q !== 1'b0) bad++;
      if (k == 1) clr_n = 1'b0;
      if (k == 6) a_n = 1'b1;
      if (k == 8) clr_n = 1'b1;
    end
    chk(bad == 0, "R10 clear over pending trigger", bad, 0);

    // R10: edge sampled together with clear low
    a_n = 1'b0; b = 1'b0; clr_n = 1'b1;
    step(20);
    b = 1'b1; clr_n = 1'b0;
    window("R10 simultaneous clear", 1, 0, 8);
    a_n = 1'b1;
    step(2);
    clr_n = 1'b1;
    window("R10 release after clear", 1, 0, 8);

    // R9: steady and non-qualifying stimuli
    len = 4'd5; a_n = 1'b0; b = 1'b1; clr_n = 1'b1;
    step(20);
    window("R9 steady levels", 1, 0, 30);
    a_n = 1'b1; b = 1'b0;
    step(20);
    b = 1'b1;
    window("R9 b rise with a high", 1, 0, 8);
    b = 1'b0;
    step(20);
    a_n = 1'b0;
    window("R9 a fall with b low", 1, 0, 8);
    a_n = 1'b1; b = 1'b1; clr_n = 1'b0;
    step(20);
    clr_n = 1'b1;
    window("R9 clr rise with a high", 1, 0, 8);
    b = 1'b0;
    window("R9 b fall", 1, 0, 8);
    a_n = 1'b0;
    step(20);
    a_n = 1'b1;
    window("R9 a rise", 1, 0, 8);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule